// File: doc/BRIEF.md
# SBC Operating Mode Controller

This block is the top-level operating-mode state machine of a CAN system basis chip. It tracks six operating states (Off, Reset, Standby, Normal, Forced Normal and Overtemp) from the battery-present, regulator-undervoltage, external-reset, overtemperature and forced-normal configuration inputs. From the current state it drives the reset output, the regulator enable, the serial-port enable and the watchdog enables. It also publishes the state code, and a transmitter-hold flag, to the CAN transceiver mode logic.

Software reaches the block through a byte-wide request port. The mode control register lives at a parameterised address, and the block answers reads on behalf of the other register banks. In Forced Normal, reads of most registers are refused. A request is accepted when `req_valid` and `req_ready` are both high on a rising clock edge. `req_ready` is high only while the serial port is enabled, so requests made in Off, Reset or Overtemp are held off rather than lost. Each accepted read yields exactly one response, with `rsp_valid` high for one cycle on the following cycle. The response side has no back-pressure, so the consumer must take it in that cycle.

Top module: `sbc_mode_ctrl`

## Requirements
- R1: `op_state` encodes Off=0, Reset=1, Standby=2, Normal=3, Forced Normal=4, Overtemp=5. While `rst_n` is low the state is Off.
- R2: With `bat_ok` low on a clock edge, the state is Off after that edge, whatever the state was before. From Off with `bat_ok` high, the next state is Reset.
- R3: The block stays in Reset while `ext_rst_req` or `v1_uv` is high. Once both are low, it leaves Reset on the next edge: to Forced Normal if `fnm_cfg` is 1, and to Standby if it is 0.
- R4: A high `ext_rst_req` or `v1_uv` in Standby, Normal or Forced Normal moves the block to Reset on the next edge.
- R5: A high `overtemp` in any powered state moves the block to Overtemp, where `v1_en` is 0. When `overtemp` falls, the next state is Reset.
- R6: `rst_out_n` and `spi_en` (and so `req_ready`) are 0 in Off, Reset and Overtemp, and 1 in Standby, Normal and Forced Normal. `v1_en` is 0 only in Off and Overtemp.
- R7: A write to address 0x01 takes its mode code from bits [2:0]. Code 3'b100 selects Standby and 3'b111 selects Normal, and the new state holds from the edge after the accepted write. Writes take effect only in Standby and Normal; in Forced Normal they are ignored.
- R8: A write of any other mode code leaves both the state and the stored code unchanged. Reading 0x01 returns the code in bits [2:0], with bits [7:3] reading 0 whatever was written to them. The stored code returns to 3'b100 in Reset.
- R9: `wd_cfg` selects the watchdog mode: 00 off, 01 timeout, 10 window, 11 timeout. `wd_en` is high only in Standby or Normal with a nonzero `wd_cfg`. `wd_window` is high only in Normal with `wd_cfg`=10, so a window setting in Standby runs as timeout.
- R10: An accepted read raises `rsp_valid` for one cycle on the next cycle. `rsp_data` carries the mode register for address 0x01, and for any other address carries the `ext_rdata` value sampled with the request.
- R11: In Forced Normal, only reads of 0x03 (main status), 0x05 (watchdog status), 0x7E (identification) and 0x70..0x74 (configuration store) succeed. Any other read returns `rsp_err`=1 with `rsp_data`=0, and this includes address 0x01.
- R12: `tx_hold` goes high when Reset is entered from Forced Normal while `v1_uv` is low. It clears when `v1_uv` rises or when Reset is left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| bat_ok | input | 1 | Battery present |
| v1_uv | input | 1 | Regulator undervoltage |
| ext_rst_req | input | 1 | External reset request |
| overtemp | input | 1 | Overtemperature condition |
| fnm_cfg | input | 1 | Forced-normal configuration bit |
| wd_cfg | input | 2 | Watchdog mode bits |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Register request accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Register address |
| req_wdata | input | 8 | Write data |
| ext_rdata | input | 8 | Read data from the other register banks |
| rsp_valid | output | 1 | Read response valid (one cycle) |
| rsp_data | output | 8 | Read response data |
| rsp_err | output | 1 | Read refused |
| op_state | output | 3 | Current operating state code |
| rst_out_n | output | 1 | Reset output level |
| v1_en | output | 1 | Regulator enable |
| spi_en | output | 1 | Serial port enable |
| wd_en | output | 1 | Watchdog enable |
| wd_window | output | 1 | Watchdog window operation |
| tx_hold | output | 1 | Keep CAN transmitter enabled through Reset |

## Verification
The bench holds the external reset across several cycles and checks that the block stays in Reset, because a design that exits Reset early would release the reset output during the fault. It releases the reset with each value of the forced-normal bit: a design that ignores the bit lands in Standby with the watchdog running. It reads the mode register in Forced Normal, where a filter that lets that read through leaks the register. It also reads a configuration-store address, where an over-strict filter refuses a legal read. Further cases cover an illegal mode code, reserved bits set in a write, the transmitter hold with and without undervoltage, and overtemperature recovery through Reset. These catch a design that changes mode on a bad code, keeps the transmitter on when the supply is low, or returns straight to Standby from Overtemp.

// File: rtl/sbc_mode_pkg.sv
package sbc_mode_pkg;
  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_RESET = 3'd1,
    ST_STBY  = 3'd2,
    ST_NORM  = 3'd3,
    ST_FNORM = 3'd4,
    ST_OTP   = 3'd5
  } op_state_t;

  localparam logic [2:0] MC_STBY = 3'b100;
  localparam logic [2:0] MC_NORM = 3'b111;

  function automatic logic is_up(op_state_t s);
    return (s == ST_STBY) || (s == ST_NORM) || (s == ST_FNORM);
  endfunction
endpackage

// File: rtl/sbc_mode_fsm.sv
module sbc_mode_fsm
  import sbc_mode_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      bat_ok,
  input  logic      v1_uv,
  input  logic      ext_rst_req,
  input  logic      overtemp,
  input  logic      fnm_cfg,
  input  logic      go_normal,
  input  logic      go_standby,
  output op_state_t state,
  output logic      tx_hold
);
  op_state_t nxt;
  logic      rst_cause;
  logic      hold_nxt;

  assign rst_cause = ext_rst_req | v1_uv;

  always_comb begin
    nxt = state;
    if (!bat_ok) begin
      nxt = ST_OFF;
    end else begin
      unique case (state)
        ST_OFF:   nxt = ST_RESET;
        ST_OTP:   if (!overtemp) nxt = ST_RESET;
        default: begin
          if (overtemp)                   nxt = ST_OTP;
          else if (rst_cause)             nxt = ST_RESET;
          else if (state == ST_RESET)     nxt = fnm_cfg ? ST_FNORM : ST_STBY;
          else if (state == ST_STBY && go_normal)  nxt = ST_NORM;
          else if (state == ST_NORM && go_standby) nxt = ST_STBY;
        end
      endcase
    end
  end

  always_comb begin
    hold_nxt = 1'b0;
    if (nxt == ST_RESET && !v1_uv)
      hold_nxt = (state == ST_FNORM) || (state == ST_RESET && tx_hold);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_OFF;
      tx_hold <= 1'b0;
    end else begin
      state   <= nxt;
      tx_hold <= hold_nxt;
    end
  end
endmodule

// File: rtl/sbc_mode_reg.sv
module sbc_mode_reg
  import sbc_mode_pkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter int          DATA_W    = 8,
  parameter logic [7:0]  MODE_ADDR = 8'h01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  op_state_t         state,
  input  logic              wr_fire,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [2:0]        mode_q,
  output logic              go_normal,
  output logic              go_standby
);
  logic [2:0] code;
  logic       code_ok;
  logic       hit;

  assign code    = wdata[2:0];
  assign code_ok = (code == MC_STBY) || (code == MC_NORM);
  assign hit     = wr_fire && (addr == ADDR_W'(MODE_ADDR)) && code_ok &&
                   ((state == ST_STBY) || (state == ST_NORM));

  assign go_normal  = hit && (code == MC_NORM);
  assign go_standby = hit && (code == MC_STBY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 mode_q <= MC_STBY;
    else if (!is_up(state))     mode_q <= MC_STBY;
    else if (hit)               mode_q <= code;
  end
endmodule

// File: rtl/sbc_read_port.sv
module sbc_read_port
  import sbc_mode_pkg::*;
#(
  parameter int         ADDR_W     = 8,
  parameter int         DATA_W     = 8,
  parameter logic [7:0] MODE_ADDR  = 8'h01,
  parameter logic [7:0] MSTAT_ADDR = 8'h03,
  parameter logic [7:0] WSTAT_ADDR = 8'h05,
  parameter logic [7:0] IDENT_ADDR = 8'h7E,
  parameter logic [7:0] CFG_FIRST  = 8'h70,
  parameter logic [7:0] CFG_LAST   = 8'h74
) (
  input  logic              clk,
  input  logic              rst_n,
  input  op_state_t         state,
  input  logic              rd_fire,
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        mode_q,
  input  logic [DATA_W-1:0] ext_rdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_err
);
  localparam int PAD_W = DATA_W - 3;

  logic              fn_allowed;
  logic              allowed;
  logic [DATA_W-1:0] src;

  assign fn_allowed = (addr == ADDR_W'(MSTAT_ADDR)) || (addr == ADDR_W'(WSTAT_ADDR)) ||
                      (addr == ADDR_W'(IDENT_ADDR)) ||
                      ((addr >= ADDR_W'(CFG_FIRST)) && (addr <= ADDR_W'(CFG_LAST)));
  assign allowed    = (state != ST_FNORM) || fn_allowed;
  assign src        = (addr == ADDR_W'(MODE_ADDR)) ? {{PAD_W{1'b0}}, mode_q} : ext_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= rd_fire;
      if (rd_fire) begin
        rsp_data <= allowed ? src : '0;
        rsp_err  <= !allowed;
      end
    end
  end
endmodule

// File: rtl/sbc_mode_ctrl.sv
module sbc_mode_ctrl
  import sbc_mode_pkg::*;
#(
  parameter int         ADDR_W     = 8,
  parameter int         DATA_W     = 8,
  parameter int         WD_W       = 2,
  parameter logic [7:0] MODE_ADDR  = 8'h01,
  parameter logic [7:0] MSTAT_ADDR = 8'h03,
  parameter logic [7:0] WSTAT_ADDR = 8'h05,
  parameter logic [7:0] IDENT_ADDR = 8'h7E,
  parameter logic [7:0] CFG_FIRST  = 8'h70,
  parameter logic [7:0] CFG_LAST   = 8'h74
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bat_ok,
  input  logic              v1_uv,
  input  logic              ext_rst_req,
  input  logic              overtemp,
  input  logic              fnm_cfg,
  input  logic [WD_W-1:0]   wd_cfg,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] ext_rdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_err,
  output logic [2:0]        op_state,
  output logic              rst_out_n,
  output logic              v1_en,
  output logic              spi_en,
  output logic              wd_en,
  output logic              wd_window,
  output logic              tx_hold
);
  localparam logic [WD_W-1:0] WD_OFF = '0;
  localparam logic [WD_W-1:0] WD_WIN = WD_W'(2);

  op_state_t  state;
  logic [2:0] mode_q;
  logic       go_normal, go_standby;
  logic       wr_fire, rd_fire;

  assign spi_en    = is_up(state);
  assign req_ready = spi_en;
  assign wr_fire   = req_valid && req_ready && req_write;
  assign rd_fire   = req_valid && req_ready && !req_write;

  assign op_state  = state;
  assign rst_out_n = is_up(state);
  assign v1_en     = (state != ST_OFF) && (state != ST_OTP);
  assign wd_en     = ((state == ST_STBY) || (state == ST_NORM)) && (wd_cfg != WD_OFF);
  assign wd_window = (state == ST_NORM) && (wd_cfg == WD_WIN);

  sbc_mode_fsm u_fsm (
    .clk, .rst_n, .bat_ok, .v1_uv, .ext_rst_req, .overtemp, .fnm_cfg,
    .go_normal, .go_standby, .state, .tx_hold
  );

  sbc_mode_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MODE_ADDR(MODE_ADDR)) u_reg (
    .clk, .rst_n, .state, .wr_fire, .addr(req_addr), .wdata(req_wdata),
    .mode_q, .go_normal, .go_standby
  );

  sbc_read_port #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MODE_ADDR(MODE_ADDR),
    .MSTAT_ADDR(MSTAT_ADDR), .WSTAT_ADDR(WSTAT_ADDR), .IDENT_ADDR(IDENT_ADDR),
    .CFG_FIRST(CFG_FIRST), .CFG_LAST(CFG_LAST)
  ) u_rd (
    .clk, .rst_n, .state, .rd_fire, .addr(req_addr), .mode_q, .ext_rdata,
    .rsp_valid, .rsp_data, .rsp_err
  );
endmodule

// File: rtl/sbc_mode_ctrl_chk.sv
module sbc_mode_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bat_ok,
  input logic       v1_uv,
  input logic       ext_rst_req,
  input logic       overtemp,
  input logic       fnm_cfg,
  input logic       req_valid,
  input logic       req_ready,
  input logic       req_write,
  input logic [7:0] req_addr,
  input logic [7:0] req_wdata,
  input logic       rsp_valid,
  input logic [2:0] op_state,
  input logic       wd_window,
  input logic       wd_en,
  input logic       v1_en,
  input logic [2:0] mode_q
);
  logic up;
  assign up = (op_state == 3'd2) || (op_state == 3'd3) || (op_state == 3'd4);

  AST_BAT_LOSS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !bat_ok |=> op_state == 3'd0); // R2

  AST_RESET_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (op_state == 3'd1 && bat_ok && !overtemp && !ext_rst_req && !v1_uv)
    |=> op_state == ($past(fnm_cfg) ? 3'd4 : 3'd2)); // R3

  AST_RST_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    (up && bat_ok && !overtemp && (ext_rst_req || v1_uv)) |=> op_state == 3'd1); // R4

  AST_OTP_REG_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (bat_ok && overtemp && op_state != 3'd0) |=> (op_state == 3'd5 && !v1_en)); // R5

  AST_BAD_CODE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write && req_addr == 8'h01 &&
     req_wdata[2:0] != 3'b100 && req_wdata[2:0] != 3'b111 &&
     bat_ok && !overtemp && !ext_rst_req && !v1_uv)
    |=> ($stable(mode_q) && $stable(op_state))); // R8

  AST_WINDOW_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
    wd_window |-> (op_state == 3'd3 && wd_en)); // R9

  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write) |=> rsp_valid); // R10
endmodule

bind sbc_mode_ctrl sbc_mode_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bat_ok(bat_ok), .v1_uv(v1_uv),
  .ext_rst_req(ext_rst_req), .overtemp(overtemp), .fnm_cfg(fnm_cfg),
  .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
  .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
  .op_state(op_state), .wd_window(wd_window), .wd_en(wd_en), .v1_en(v1_en),
  .mode_q(mode_q)
);

// File: tb/sbc_mode_ctrl_bench.sv
`timescale 1ns/1ps
module sbc_mode_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bat_ok = 1'b0, v1_uv = 1'b0, ext_rst_req = 1'b0, overtemp = 1'b0, fnm_cfg = 1'b0;
  logic [1:0] wd_cfg = 2'b00;
  logic       req_valid = 1'b0, req_write = 1'b0;
  logic [7:0] req_addr = '0, req_wdata = '0, ext_rdata = '0;
  logic       req_ready, rsp_valid, rsp_err;
  logic [7:0] rsp_data;
  logic [2:0] op_state;
  logic       rst_out_n, v1_en, spi_en, wd_en, wd_window, tx_hold;

  int n_tests = 0;
  int n_fail  = 0;
  logic [8:0] exp_q[$];   // {err, data}

  always #2 clk = ~clk;

  sbc_mode_ctrl u_sbc_mode_ctrl (
    .clk, .rst_n, .bat_ok, .v1_uv, .ext_rst_req, .overtemp, .fnm_cfg, .wd_cfg,
    .req_valid, .req_ready, .req_write, .req_addr, .req_wdata, .ext_rdata,
    .rsp_valid, .rsp_data, .rsp_err, .op_state, .rst_out_n, .v1_en, .spi_en,
    .wd_en, .wd_window, .tx_hold
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  // Outputs as one vector: {rst_out_n, spi_en, v1_en, wd_en, wd_window, tx_hold}
  function automatic logic [7:0] pins();
    return {2'b00, rst_out_n, spi_en, v1_en, wd_en, wd_window, tx_hold};
  endfunction

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    step();
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  // driver: pushes the expected response, then issues the read
  task automatic rd(input logic [7:0] a, input logic [7:0] exp_d, input logic exp_e);
    exp_q.push_back({exp_e, exp_d});
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; ext_rdata = a ^ 8'h5A;
    step();
    req_valid = 1'b0;
  endtask

  // monitor: pops and compares on each response
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      n_tests++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R10: actual unexpected response %0h expected none", rsp_data);
      end else begin
        logic [8:0] e;
        e = exp_q.pop_front();
        if ({rsp_err, rsp_data} !== e) begin
          n_fail++;
          $display("FAIL R10/R11: actual %0h expected %0h", {rsp_err, rsp_data}, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    step(2);
    chk({5'b0, op_state}, 8'd0, "R1 off in reset");
    rst_n = 1'b1;
    step(2);
    chk({5'b0, op_state}, 8'd0, "R2 off without battery");
    chk(pins(), 8'b000000, "R6 off pins");
    bat_ok = 1'b1; wd_cfg = 2'b10;
    step();
    chk({5'b0, op_state}, 8'd1, "R2 battery to reset");
    chk(pins(), 8'b001000, "R6 reset pins");
    step();
    chk({5'b0, op_state}, 8'd2, "R3 reset to standby");
    chk(pins(), 8'b111100, "R6 R9 standby pins, window runs as timeout");
    rd(8'h01, 8'h04, 1'b0);                       // R10 mode readback
    rd(8'h03, 8'h03 ^ 8'h5A, 1'b0);               // R10 external data
    wr(8'h01, 8'hFF);
    chk({5'b0, op_state}, 8'd3, "R7 write 111 to normal");
    chk(pins(), 8'b111110, "R9 window in normal");
    rd(8'h01, 8'h07, 1'b0);                       // R8 reserved bits read 0
    wr(8'h01, 8'h05);
    chk({5'b0, op_state}, 8'd3, "R8 bad code ignored");
    rd(8'h01, 8'h07, 1'b0);                       // R8 code kept
    wd_cfg = 2'b00;
    step();
    chk(pins(), 8'b111000, "R9 watchdog off by cfg");
    wr(8'h01, 8'h04);
    chk({5'b0, op_state}, 8'd2, "R7 write 100 to standby");
    ext_rst_req = 1'b1;
    step();
    chk({5'b0, op_state}, 8'd1, "R4 external reset");
    step(3);
    chk({5'b0, op_state}, 8'd1, "R3 held in reset");
    fnm_cfg = 1'b1; ext_rst_req = 1'b0; wd_cfg = 2'b01;
    step();
    chk({5'b0, op_state}, 8'd4, "R3 exit to forced normal");
    chk(pins(), 8'b111000, "R6 R9 forced normal pins");
    rd(8'h01, 8'h00, 1'b1);                       // R11 mode register refused
    rd(8'h05, 8'h05 ^ 8'h5A, 1'b0);               // R11 watchdog status
    rd(8'h72, 8'h72 ^ 8'h5A, 1'b0);               // R11 config store
    rd(8'h7E, 8'h7E ^ 8'h5A, 1'b0);               // R11 identification
    rd(8'h40, 8'h00, 1'b1);                       // R11 other refused
    wr(8'h01, 8'h07);
    chk({5'b0, op_state}, 8'd4, "R7 write ignored in forced normal");
    ext_rst_req = 1'b1;
    step();
    chk({5'b0, op_state}, 8'd1, "R4 reset from forced normal");
    chk({7'b0, tx_hold}, 8'd1, "R12 hold without undervoltage");
    v1_uv = 1'b1;
    step();
    chk({7'b0, tx_hold}, 8'd0, "R12 hold cleared by undervoltage");
    ext_rst_req = 1'b0; v1_uv = 1'b0;
    step();
    chk({5'b0, op_state}, 8'd4, "R3 back to forced normal");
    v1_uv = 1'b1;
    step();
    chk({5'b0, op_state}, 8'd1, "R4 undervoltage reset");
    chk({7'b0, tx_hold}, 8'd0, "R12 no hold with undervoltage");
    v1_uv = 1'b0; fnm_cfg = 1'b0;
    step();
    chk({5'b0, op_state}, 8'd2, "R3 exit to standby");
    overtemp = 1'b1;
    step();
    chk({5'b0, op_state}, 8'd5, "R5 overtemp");
    chk(pins(), 8'b000000, "R5 R6 overtemp pins");
    step(2);
    chk({5'b0, op_state}, 8'd5, "R5 held in overtemp");
    overtemp = 1'b0;
    step();
    chk({5'b0, op_state}, 8'd1, "R5 overtemp clear to reset");
    step();
    wr(8'h01, 8'h07);
    chk({5'b0, op_state}, 8'd3, "R7 normal again");
    bat_ok = 1'b0;
    step();
    chk({5'b0, op_state}, 8'd0, "R2 battery loss");
    step(2);
    n_tests++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R10: actual %0d responses missing expected 0", exp_q.size());
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule